// File: doc/BRIEF.md
# ADC Conversion Frame Master

This block is the host-side serial master for a 14-bit successive-approximation converter that is clocked by the host. A single-cycle start request and a channel number make the block pull chip select low and run one conversion frame of a fixed length, 32 serial clocks. The opening byte that the block shifts out is a conversion-start command for the requested channel. The 14-bit result then comes back on the converter's data line, most significant bit first. The converter updates its data line on falling serial clock edges, and the master samples it on the rising edge that follows.

When the frame ends, chip select returns high and the block raises a one-cycle done strobe. The captured offset-binary code is published alongside a sign-extended two's-complement copy of the same value. The serial clock is produced by a programmable divider from the system clock. While a frame or the inter-frame gap is in progress the block is busy, and a start request in that time is discarded. Chip select stays high for a programmable gap of at least one serial clock period before the next frame can begin.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, busy_o is 0, done_o is 0 and code_o is 0.
- R2: A start_i sampled high while idle drives cs_n_o low at the next clock edge. Each frame has exactly FRAME_CLKS (default 32) rising sclk_o edges while cs_n_o is low. sclk_o is low whenever cs_n_o is high.
- R3: Every sclk_o level lasts HALF_DIV system clocks. The first rising sclk_o edge comes HALF_DIV clocks after cs_n_o falls.
- R4: mosi_o carries the command byte {1, chan[2], chan[1], chan[0], 0, 0, 0, 0}, leftmost bit first, valid at rising sclk_o edges 1 to 8. mosi_o changes only while sclk_o is low. It is 0 at rising edges 9 to 32.
- R5: miso_i is sampled on rising sclk_o edges RES_FIRST to RES_FIRST+13 (defaults 10 to 23). The first sampled bit lands in code_o[13] and the last in code_o[0].
- R6: done_o is high for exactly one cycle, in the cycle where cs_n_o returns high. code_o and signed_o take the new result in that same cycle and hold it until the next done_o.
- R7: signed_o equals code_o minus 0x2000, sign-extended to 16 bits. So 0x2000 gives 0, 0x0000 gives -8192 and 0x3FFF gives 8191.
- R8: A start_i seen while busy_o is 1 has no effect, including a start in the done cycle. chan_i changes during a frame do not alter the command already being sent.
- R9: Between frames cs_n_o stays high for at least 2*GAP_CLKS*HALF_DIV clocks. With start_i held high, the next frame's cs_n_o falls after exactly 2*GAP_CLKS*HALF_DIV+1 high cycles.
- R10: miso_i values outside the result window do not affect code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | CH_W (3) | Channel number for the command byte |
| cs_n_o | output | 1 | Active-low converter chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Result data from the converter |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle strobe when a result is published |
| code_o | output | RES_BITS (14) | Offset-binary result |
| signed_o | output | OUT_W (16) | Two's-complement result, sign-extended |

## Verification
Two events can fall on the same clock: the end of a frame, where the done strobe fires and chip select rises, and a new start request from the host. The bench provokes this by raising start_i in exactly the done cycle, and separately by holding start_i high across two frames. The cycle-accurate reference model then requires chip select to stay high through the full gap, so any frame that began early would show up as a chip-select or serial-clock mismatch on that very cycle. A count of chip-select falling edges is also compared against the frames the model accepted.

// File: rtl/adcm_pkg.sv
`timescale 1ns/1ps
package adcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } fsm_e;

endpackage

// File: rtl/adcm_tick_gen.sv
`timescale 1ns/1ps
module adcm_tick_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == LAST);
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the divider never runs past one half period
    a_r3_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/adcm_cmd_ser.sv
`timescale 1ns/1ps
module adcm_cmd_ser #(
    parameter int CMD_BITS = 8,
    parameter int CH_W     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            shift_i,
    output logic            bit_o
);
    logic [CMD_BITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = '0;
            sr_d[CMD_BITS-1] = 1'b1;
            sr_d[CMD_BITS-2 -: CH_W] = chan_i;
        end else if (shift_i) begin
            sr_d = {sr_q[CMD_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q[CMD_BITS-1];

    // R4: a freshly loaded command always opens with the start bit
    a_r4_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> bit_o);

endmodule

// File: rtl/adcm_res_cap.sv
`timescale 1ns/1ps
module adcm_res_cap #(
    parameter int RES_BITS = 14,
    parameter int OUT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                sample_i,
    input  logic                bit_i,
    input  logic                commit_i,
    output logic [RES_BITS-1:0] code_o,
    output logic [OUT_W-1:0]    signed_o
);
    localparam int EXT = OUT_W - RES_BITS;

    typedef struct packed {
        logic [RES_BITS-1:0] sh;
        logic [RES_BITS-1:0] code;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear_i)       c_d.sh = '0;
        else if (sample_i) c_d.sh = {c_q.sh[RES_BITS-2:0], bit_i};
        if (commit_i)      c_d.code = c_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign code_o   = c_q.code;
    assign signed_o = {{EXT{~c_q.code[RES_BITS-1]}}, ~c_q.code[RES_BITS-1],
                       c_q.code[RES_BITS-2:0]};

    // R6: the published code moves only right after a commit
    a_r6_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_i) |-> $stable(code_o));

endmodule

// File: rtl/adc_frame_master.sv
`timescale 1ns/1ps
module adc_frame_master
    import adcm_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int FRAME_CLKS = 32,
    parameter int CMD_BITS   = 8,
    parameter int CH_W       = 3,
    parameter int RES_BITS   = 14,
    parameter int RES_FIRST  = 10,
    parameter int GAP_CLKS   = 1,
    parameter int OUT_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] code_o,
    output logic [OUT_W-1:0]    signed_o
);
    localparam int HC_MAX = (FRAME_CLKS > GAP_CLKS) ? 2 * FRAME_CLKS : 2 * GAP_CLKS;
    localparam int HC_W   = $clog2(HC_MAX + 1);
    localparam logic [HC_W-1:0] RUN_LAST = HC_W'(2 * FRAME_CLKS - 1);
    localparam logic [HC_W-1:0] GAP_LAST = HC_W'(2 * GAP_CLKS - 1);
    localparam logic [HC_W-1:0] WIN_LO   = HC_W'(2 * (RES_FIRST - 1));
    localparam logic [HC_W-1:0] WIN_HI   = HC_W'(2 * (RES_FIRST + RES_BITS - 2));

    typedef struct packed {
        fsm_e            st;
        logic [HC_W-1:0] hcnt;
        logic            cs_n;
        logic            sclk;
        logic            done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, hcnt: '0, cs_n: 1'b1, sclk: 1'b0, done: 1'b0};

    ctl_t r_d, r_q;
    logic tick, load, shift, sample, commit;

    adcm_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.st != ST_IDLE),
        .tick_o (tick)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        load   = 1'b0;
        shift  = 1'b0;
        sample = 1'b0;
        commit = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RUN;
                    r_d.cs_n = 1'b0;
                    r_d.sclk = 1'b0;
                    r_d.hcnt = '0;
                    load     = 1'b1;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    r_d.hcnt = r_q.hcnt + 1'b1;
                    if (!r_q.hcnt[0]) begin
                        r_d.sclk = 1'b1;
                        sample   = (r_q.hcnt >= WIN_LO) && (r_q.hcnt <= WIN_HI);
                    end else begin
                        r_d.sclk = 1'b0;
                        shift    = 1'b1;
                        if (r_q.hcnt == RUN_LAST) begin
                            r_d.st   = ST_GAP;
                            r_d.cs_n = 1'b1;
                            r_d.done = 1'b1;
                            r_d.hcnt = '0;
                            commit   = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    r_d.hcnt = r_q.hcnt + 1'b1;
                    if (r_q.hcnt == GAP_LAST) begin
                        r_d.st   = ST_IDLE;
                        r_d.hcnt = '0;
                    end
                end
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    adcm_cmd_ser #(.CMD_BITS(CMD_BITS), .CH_W(CH_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .chan_i  (chan_i),
        .shift_i (shift),
        .bit_o   (mosi_o)
    );

    adcm_res_cap #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .sample_i (sample),
        .bit_i    (miso_i),
        .commit_i (commit),
        .code_o   (code_o),
        .signed_o (signed_o)
    );

    assign cs_n_o = r_q.cs_n;
    assign sclk_o = r_q.sclk;
    assign done_o = r_q.done;
    assign busy_o = (r_q.st != ST_IDLE);

    // R2: serial clock rests low while deselected
    a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R6: the strobe coincides with chip select returning high
    a_r6_done_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !$past(cs_n_o)));

    // R4: command data is steady while the clock is high
    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R8: during the gap a start cannot pull chip select low
    a_r8_gap_keeps_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cs_n_o) |=> cs_n_o);

endmodule

// File: tb/tb_adc_frame_master.sv
`timescale 1ns/1ps
module tb_adc_frame_master;
    localparam int HALF   = 4;
    localparam int FRAME  = 32;
    localparam int GAP    = 1;
    localparam int RFIRST = 10;
    localparam int RB     = 14;
    localparam int LIMIT  = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic cs_n_o, sclk_o, mosi_o, miso_i, busy_o, done_o;
    logic [13:0] code_o;
    logic [15:0] signed_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    adc_frame_master #(.HALF_DIV(HALF), .FRAME_CLKS(FRAME), .GAP_CLKS(GAP),
                       .RES_FIRST(RFIRST)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .busy_o(busy_o), .done_o(done_o), .code_o(code_o), .signed_o(signed_o));

    // ---------------- converter model ----------------
    logic [13:0] slave_code = '0;
    logic noise = 1'b0;
    int fcnt = 0;
    logic sl_win = 1'b0;
    logic sl_bit = 1'b0;
    assign miso_i = sl_win ? sl_bit : noise;

    always @(negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) begin
            fcnt = 0;
            sl_win = 1'b0;
        end else if (!sclk_o) begin
            fcnt = fcnt + 1;
            if (fcnt + 1 >= RFIRST && fcnt + 1 <= RFIRST + RB - 1) begin
                sl_win = 1'b1;
                sl_bit = slave_code[RB - 1 - (fcnt + 1 - RFIRST)];
            end else begin
                sl_win = 1'b0;
            end
        end
    end

    int rcnt = 0;
    int extra = 0;
    logic [7:0] cmd_rx = '0;
    always @(posedge sclk_o or negedge cs_n_o) begin
        if (!sclk_o) begin
            rcnt = 0; extra = 0; cmd_rx = '0;
        end else if (!cs_n_o) begin
            rcnt = rcnt + 1;
            if (rcnt <= 8) cmd_rx = {cmd_rx[6:0], mosi_o};
            else if (mosi_o) extra = extra + 1;
        end
    end

    // ---------------- reference model, compared every clock ----------------
    logic m_busy = 1'b0;
    int m_k = 0;
    logic [2:0] m_chan = '0;
    logic [13:0] m_code = '0;
    int m_frames = 0;
    int dut_frames = 0;
    int hi_run = 0;
    int last_gap = 0;
    logic prev_cs = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int m;
        logic e_cs, e_sclk, e_done;
        #1;
        cyc++;
        if (!rst_n) begin
            m_busy = 1'b0; m_k = 0;
        end else begin
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1'b1; m_k = 0; m_chan = chan_i;
                    m_code = slave_code; m_frames++;
                end
            end else begin
                m_k++;
                if (m_k >= (2 * FRAME + 2 * GAP) * HALF) m_busy = 1'b0;
            end
            e_cs = 1'b1; e_sclk = 1'b0; e_done = 1'b0;
            if (m_busy) begin
                m = m_k / HALF;
                if (m < 2 * FRAME) begin
                    e_cs = 1'b0; e_sclk = m[0];
                end
                e_done = (m_k == 2 * FRAME * HALF);
            end
            chk(cs_n_o == e_cs, "R2 cs_n", cs_n_o, e_cs);
            chk(sclk_o == e_sclk, "R3 sclk", sclk_o, e_sclk);
            chk(busy_o == m_busy, "R8 busy", busy_o, m_busy);
            chk(done_o == e_done, "R6 done", done_o, e_done);
            if (e_done) begin
                chk(code_o == m_code, "R5 code", code_o, m_code);
                chk(int'($signed(signed_o)) == int'(m_code) - 8192, "R7 signed",
                    int'($signed(signed_o)), int'(m_code) - 8192);
                chk(cmd_rx == {1'b1, m_chan, 4'b0000}, "R4 command byte", cmd_rx,
                    {1'b1, m_chan, 4'b0000});
                chk(extra == 0, "R4 trailing mosi", extra, 0);
                chk(rcnt == FRAME, "R2 rising edges", rcnt, FRAME);
            end
            if (!e_done && !m_busy) begin
                chk(code_o == m_code, "R6 code hold", code_o, m_code);
            end
            if (prev_cs && !cs_n_o) begin
                dut_frames++;
                last_gap = hi_run;
                hi_run = 0;
            end
            if (cs_n_o) hi_run++;
            prev_cs = cs_n_o;
        end
        if (cyc > LIMIT) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic do_frame(input logic [2:0] ch, input logic [13:0] code);
        wait_idle();
        slave_code = code;
        chan_i = ch;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(code_o == 14'h0, "R1 code", code_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 R7: boundary and pattern codes on several channels
        do_frame(3'd0, 14'h2000);
        do_frame(3'd7, 14'h0000);
        do_frame(3'd5, 14'h3FFF);
        do_frame(3'd2, 14'h2AAA);
        do_frame(3'd4, 14'h1555);
        do_frame(3'd1, 14'h2001);

        // R10: line held high outside the window, zero result inside it
        noise = 1'b1;
        do_frame(3'd6, 14'h0000);
        chk(code_o == 14'h0000, "R10 noise ignored", code_o, 0);
        noise = 1'b0;

        // R8: start in the done cycle, channel change mid-frame
        wait_idle();
        slave_code = 14'h1234;
        chan_i = 3'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        chan_i = 3'd6;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        start_i = 1'b1;
        chan_i = 3'd1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(dut_frames == m_frames, "R8 frame count", dut_frames, m_frames);
        chk(busy_o == 1'b0, "R8 no extra frame", busy_o, 0);

        // R9: start held high, back-to-back frames
        begin
            int f0;
            f0 = m_frames;
            slave_code = 14'h3001;
            chan_i = 3'd2;
            start_i = 1'b1;
            while (m_frames < f0 + 2) @(negedge clk);
            start_i = 1'b0;
            wait_idle();
        end
        chk(last_gap == 2 * GAP * HALF + 1, "R9 gap length", last_gap, 2 * GAP * HALF + 1);
        chk(dut_frames == m_frames, "R9 frame count", dut_frames, m_frames);

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule